// File: doc/BRIEF.md
# Serial Neuron Layer MAC Array

This block computes one fully connected neural-network layer. There is one multiply-accumulate unit per neuron, each shaped like a hard DSP slice: an 18-bit signed weight times a 27-bit signed activation, added into a 48-bit signed accumulator. Activations come in one per cycle on a valid/ready stream and go to every neuron unit at once. Each unit uses the weight that belongs to its own neuron and to the current position in the vector.

A vector has `N_IN` elements. On the first element, every unit loads its bias plus the product. On each later element, it adds the product to its running sum. When the last element has been accumulated, all `N_NEU` sums are captured together into an output shift register, and the units can start the next vector at once. The captured sums are shaped for the next layer by an optional ReLU, a fixed-point right shift and saturation to 27 bits. They then leave one per cycle on a valid/ready stream, with a flag on the final neuron of each vector.

When a layer has more neurons than inputs, the output side cannot keep up with the input side. In that case the block holds the finished sums in the accumulators and lowers its input ready until the previous vector has drained. Weights and biases are written through a simple write port. The control pipeline depth, `LAT`, can be set from 1 to 3.

Top module: `nnl_layer`

## Requirements
- R1: A write with `cfg_is_bias`=0 stores `cfg_value[17:0]` as the weight that neuron `cfg_neuron` applies to element `cfg_index`. A write with `cfg_is_bias`=1 stores all 48 bits of `cfg_value` as that neuron's bias. Later vectors use the new value.
- R2: For each vector, neuron n produces bias[n] + sum over k of weight[n][k]·x[k] in 48-bit signed arithmetic. Element k is the k-th accepted input since reset or since the end of the previous vector.
- R3: Each vector produces exactly `N_NEU` output beats in neuron order 0 first. `out_last` is 1 on the final beat of the vector and 0 on every other beat. Vectors leave in the order they arrived.
- R4: With `RELU_EN`=1, a negative sum is output as 0. With `RELU_EN`=0, negative sums pass through with their sign.
- R5: The output value is the (ReLU-processed) sum arithmetically shifted right by `FRAC` bits. It is then saturated to the 27-bit signed range [-2^26, 2^26-1].
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R7: No result is lost or overwritten under any `out_ready` pattern. When `N_NEU` > `N_IN` and inputs are offered back to back, `in_ready` drops for some cycles. When `N_NEU` ≤ `N_IN`, `LAT`=1 and `out_ready` stays 1, `in_ready` stays 1 for back-to-back vectors.
- R8: With the output buffer empty, `out_valid` rises right after the `LAT`-th rising edge, counting the edge that accepts the last element of a vector as the first.
- R9: After reset, `out_valid`=0, `in_ready`=1, and the next accepted input is element 0 of a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_is_bias | input | 1 | 1 writes a bias, 0 writes a weight |
| cfg_neuron | input | max(1,clog2(N_NEU)) | Target neuron |
| cfg_index | input | max(1,clog2(N_IN)) | Vector element the weight applies to |
| cfg_value | input | 48 | Coefficient value (weight uses bits 17:0) |
| in_valid | input | 1 | Input activation valid |
| in_ready | output | 1 | Layer accepts an activation this cycle |
| in_data | input | 27 | Signed input activation |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Downstream accepts a result |
| out_data | output | 27 | Shaped signed neuron result |
| out_last | output | 1 | Marks the last neuron of a vector |

## Verification
The hardest situation to reach is a finished vector that cannot be captured because the previous vector is still draining. The sums must then wait in the accumulators while the next vector's first element is held off. The bench reaches this with a layer that has more neurons than inputs, fed back to back, with the output ready driven both continuously and with a random stall pattern. It compares every beat against a reference computed in the bench and counts the cycles in which input ready was low. A second layer, with fewer neurons than inputs and no extra latency, checks that the same traffic flows with no stall at all. Large coefficient values drive the shift-and-saturate path to both limits.

// File: rtl/nnl_pkg.sv
`timescale 1ns/1ps
package nnl_pkg;
    localparam int W_WGT = 18;
    localparam int W_ACT = 27;
    localparam int W_ACC = 48;

    typedef logic signed [W_WGT-1:0] wgt_t;
    typedef logic signed [W_ACT-1:0] act_t;
    typedef logic signed [W_ACC-1:0] acc_t;

    localparam acc_t ACT_HI = acc_t'((64'sd1 <<< (W_ACT-1)) - 1);
    localparam acc_t ACT_LO = -acc_t'(64'sd1 <<< (W_ACT-1));

    // ReLU (optional), arithmetic scale-down, then clamp to activation width
    function automatic act_t shape_result(acc_t sum, bit relu, int frac);
        acc_t v;
        acc_t s;
        v = (relu && sum < 0) ? '0 : sum;
        s = v >>> frac;
        if (s > ACT_HI)
            return act_t'(ACT_HI);
        else if (s < ACT_LO)
            return act_t'(ACT_LO);
        else
            return act_t'(s);
    endfunction
endpackage

// File: rtl/nnl_coef_store.sv
`timescale 1ns/1ps
module nnl_coef_store
    import nnl_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_NEU = 5,
    parameter int IW    = 2,
    parameter int NW    = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bias,
    input  logic [NW-1:0] wr_neu,
    input  logic [IW-1:0] wr_idx,
    input  acc_t          wr_val,
    input  logic [IW-1:0] rd_idx,
    output wgt_t          w_sel [N_NEU],
    output acc_t          b_all [N_NEU]
);
    wgt_t wmem [N_NEU][N_IN];
    acc_t bmem [N_NEU];

    always_ff @(posedge clk) begin
        if (wr_en && int'(wr_neu) < N_NEU) begin
            if (wr_bias)
                bmem[wr_neu] <= wr_val;
            else if (int'(wr_idx) < N_IN)
                wmem[wr_neu][wr_idx] <= wr_val[W_WGT-1:0];
        end
    end

    always_comb begin
        for (int n = 0; n < N_NEU; n++) begin
            w_sel[n] = wmem[n][rd_idx];
            b_all[n] = bmem[n];
        end
    end
endmodule

// File: rtl/nnl_delay.sv
`timescale 1ns/1ps
module nnl_delay #(
    parameter int W   = 8,
    parameter int STG = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STG == 0) begin : g_pass
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] pipe [STG];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STG; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STG; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[STG-1];
        end
    endgenerate
endmodule

// File: rtl/nnl_mac.sv
`timescale 1ns/1ps
module nnl_mac
    import nnl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic first,
    input  act_t x,
    input  wgt_t w,
    input  acc_t bias,
    output acc_t acc_q,
    output acc_t acc_d
);
    acc_t prod;
    assign prod  = acc_t'(w) * acc_t'(x);
    // two operating modes: bias-load on element 0, accumulate afterwards
    assign acc_d = (first ? bias : acc_q) + prod;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_d;
    end
endmodule

// File: rtl/nnl_out_ser.sv
`timescale 1ns/1ps
module nnl_out_ser
    import nnl_pkg::*;
#(
    parameter int N_NEU   = 5,
    parameter int RELU_EN = 1,
    parameter int FRAC    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  acc_t vals [N_NEU],
    input  logic out_ready,
    output logic out_valid,
    output act_t out_data,
    output logic out_last,
    output logic free
);
    localparam int CW = $clog2(N_NEU + 1);

    act_t          sreg [N_NEU];
    logic [CW-1:0] cnt;

    assign out_valid = (cnt != '0);
    assign out_last  = (cnt == CW'(1));
    assign out_data  = sreg[0];
    assign free      = (cnt == '0) || (cnt == CW'(1) && out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < N_NEU; i++) sreg[i] <= '0;
        end else if (load) begin
            cnt <= CW'(N_NEU);
            for (int i = 0; i < N_NEU; i++)
                sreg[i] <= shape_result(vals[i], RELU_EN != 0, FRAC);
        end else if (out_valid && out_ready) begin
            cnt <= cnt - CW'(1);
            for (int i = 0; i + 1 < N_NEU; i++) sreg[i] <= sreg[i+1];
        end
    end

    // independent beat position counter for checking the last flag
    logic [CW-1:0] beat;
    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else if (out_valid && out_ready)
            beat <= (beat == CW'(N_NEU - 1)) ? '0 : beat + CW'(1);
    end

    assert_last_beat_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (beat == CW'(N_NEU - 1))));

    assert_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    generate
        if (RELU_EN != 0) begin : g_relu_chk
            assert_relu_R4: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> !out_data[W_ACT-1]);
        end
    endgenerate
endmodule

// File: rtl/nnl_layer.sv
`timescale 1ns/1ps
module nnl_layer
    import nnl_pkg::*;
#(
    parameter int N_IN    = 3,
    parameter int N_NEU   = 5,
    parameter int LAT     = 2,
    parameter int RELU_EN = 1,
    parameter int FRAC    = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cfg_we,
    input  logic                                  cfg_is_bias,
    input  logic [((N_NEU > 1) ? $clog2(N_NEU) : 1)-1:0] cfg_neuron,
    input  logic [((N_IN > 1) ? $clog2(N_IN) : 1)-1:0]   cfg_index,
    input  logic [47:0]                           cfg_value,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [26:0]                           in_data,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [26:0]                           out_data,
    output logic                                  out_last
);
    localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int NW  = (N_NEU > 1) ? $clog2(N_NEU) : 1;
    localparam int DLY = LAT - 1;
    localparam int DW  = 3 + IW + W_ACT;
    localparam bit EARLY_FREE = (N_IN > 1);

    // ---------------- input sequencing ----------------
    logic [IW-1:0] idx_q;
    logic          accept, first_in, last_in;
    logic          lip_q;     // a last element is still in the control delay line
    logic          hold_q;    // finished sums waiting in the accumulators
    logic          free;

    assign first_in = (idx_q == '0);
    assign last_in  = (idx_q == IW'(N_IN - 1));
    assign in_ready = !first_in || (!lip_q && (!hold_q || (free && EARLY_FREE)));
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (accept)
            idx_q <= last_in ? '0 : idx_q + IW'(1);
    end

    // ---------------- control delay to MAC stage ----------------
    logic          m_vld, m_first, m_last;
    logic [IW-1:0] m_idx;
    act_t          m_x;
    logic [DW-1:0] d_in, d_out;

    assign d_in = {accept, first_in, last_in, idx_q, in_data};
    assign {m_vld, m_first, m_last, m_idx, m_x} = d_out;

    nnl_delay #(.W(DW), .STG(DLY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (d_in),
        .q   (d_out)
    );

    generate
        if (DLY == 0) begin : g_nolip
            assign lip_q = 1'b0;
        end else begin : g_lip
            logic lip_r;
            always_ff @(posedge clk) begin
                if (rst)
                    lip_r <= 1'b0;
                else if (accept && last_in)
                    lip_r <= 1'b1;
                else if (m_vld && m_last)
                    lip_r <= 1'b0;
            end
            assign lip_q = lip_r;
        end
    endgenerate

    // ---------------- coefficients and MAC units ----------------
    wgt_t w_sel [N_NEU];
    acc_t b_all [N_NEU];
    acc_t acc_q [N_NEU];
    acc_t acc_d [N_NEU];
    acc_t cap_v [N_NEU];

    nnl_coef_store #(.N_IN(N_IN), .N_NEU(N_NEU), .IW(IW), .NW(NW)) u_coef (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_bias (cfg_is_bias),
        .wr_neu  (cfg_neuron),
        .wr_idx  (cfg_index),
        .wr_val  (acc_t'(cfg_value)),
        .rd_idx  (m_idx),
        .w_sel   (w_sel),
        .b_all   (b_all)
    );

    generate
        for (genvar n = 0; n < N_NEU; n++) begin : g_neu
            nnl_mac u_mac (
                .clk   (clk),
                .rst   (rst),
                .en    (m_vld),
                .first (m_first),
                .x     (m_x),
                .w     (w_sel[n]),
                .bias  (b_all[n]),
                .acc_q (acc_q[n]),
                .acc_d (acc_d[n])
            );
            assign cap_v[n] = hold_q ? acc_q[n] : acc_d[n];
        end
    endgenerate

    // ---------------- capture / hold ----------------
    logic cap_now, load;
    assign cap_now = m_vld && m_last;
    assign load    = (cap_now || hold_q) && free;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (cap_now && !free)
            hold_q <= 1'b1;
        else if (hold_q && free)
            hold_q <= 1'b0;
    end

    // ---------------- output serialiser ----------------
    act_t o_data;
    nnl_out_ser #(.N_NEU(N_NEU), .RELU_EN(RELU_EN), .FRAC(FRAC)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .vals      (cap_v),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (o_data),
        .out_last  (out_last),
        .free      (free)
    );
    assign out_data = o_data;

    // ---------------- assertions ----------------
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        (m_vld && m_first) |-> (!hold_q || free));

    assert_no_double_R7: assert property (@(posedge clk) disable iff (rst)
        cap_now |-> !hold_q);

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));
endmodule

// File: tb/nnl_case.sv
`timescale 1ns/1ps
module nnl_case #(
    parameter int    N_IN    = 3,
    parameter int    N_NEU   = 5,
    parameter int    LAT     = 2,
    parameter int    RELU_EN = 1,
    parameter int    FRAC    = 4,
    parameter string TAG     = "case"
) (
    input  logic clk,
    input  logic go,
    output logic fin,
    output int   n_chk,
    output int   n_err
);
    localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int NW   = (N_NEU > 1) ? $clog2(N_NEU) : 1;
    localparam int VMAX = 8;

    logic          rst, cfg_we, cfg_is_bias;
    logic [NW-1:0] cfg_neuron;
    logic [IW-1:0] cfg_index;
    logic [47:0]   cfg_value;
    logic          in_valid, in_ready, out_valid, out_ready, out_last;
    logic [26:0]   in_data, out_data;

    nnl_layer #(.N_IN(N_IN), .N_NEU(N_NEU), .LAT(LAT),
                .RELU_EN(RELU_EN), .FRAC(FRAC)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_bias(cfg_is_bias),
        .cfg_neuron(cfg_neuron), .cfg_index(cfg_index), .cfg_value(cfg_value),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    longint wm [N_NEU][N_IN];
    longint bm [N_NEU];
    longint xm [VMAX][N_IN];
    longint expq [VMAX*N_NEU];
    int     cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", TAG, req, act, exp);
        end
    endtask

    function automatic longint ref_out(longint a);
        longint v;
        v = (RELU_EN != 0 && a < 0) ? 0 : a;
        v = v >>> FRAC;
        if (v > (64'sd1 <<< 26) - 1) v = (64'sd1 <<< 26) - 1;
        if (v < -(64'sd1 <<< 26)) v = -(64'sd1 <<< 26);
        return v;
    endfunction

    function automatic longint rnd(bit big, int bits_small);
        if (big) return longint'($signed(18'($urandom)));
        return longint'($urandom_range(0, (1 << bits_small) - 1)) - (64'sd1 <<< (bits_small - 1));
    endfunction

    task automatic gen_coefs(bit big);
        for (int n = 0; n < N_NEU; n++) begin
            for (int k = 0; k < N_IN; k++) wm[n][k] = rnd(big, 10);
            bm[n] = big ? longint'($signed(44'({$urandom, $urandom})))
                        : longint'($urandom_range(0, 1 << 20)) - (64'sd1 <<< 19);
        end
    endtask

    task automatic gen_inputs(int nv, bit big);
        for (int v = 0; v < nv; v++)
            for (int k = 0; k < N_IN; k++)
                xm[v][k] = big ? longint'($signed(27'($urandom))) : rnd(1'b0, 13);
    endtask

    task automatic compute_exp(int nv);
        for (int v = 0; v < nv; v++)
            for (int n = 0; n < N_NEU; n++) begin
                longint acc = bm[n];
                for (int k = 0; k < N_IN; k++) acc += wm[n][k] * xm[v][k];
                expq[v*N_NEU + n] = ref_out(acc);
            end
    endtask

    task automatic write_coefs();
        for (int n = 0; n < N_NEU; n++) begin
            for (int k = 0; k < N_IN; k++) begin
                @(negedge clk);
                cfg_we = 1; cfg_is_bias = 0;
                cfg_neuron = NW'(n); cfg_index = IW'(k); cfg_value = 48'(wm[n][k]);
            end
            @(negedge clk);
            cfg_we = 1; cfg_is_bias = 1;
            cfg_neuron = NW'(n); cfg_index = '0; cfg_value = 48'(bm[n]);
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    // mode 0: always ready, 1: alternate, 2: random stalls
    task automatic run_stream(int nv, int mode, string req, output int stalls);
        int st = 0;
        fork
            begin
                for (int v = 0; v < nv; v++)
                    for (int k = 0; k < N_IN; k++) begin
                        @(negedge clk);
                        in_valid = 1; in_data = xm[v][k][26:0];
                        #1;
                        while (!in_ready) begin
                            st++;
                            @(negedge clk);
                            #1;
                        end
                        @(posedge clk);
                    end
                @(negedge clk);
                in_valid = 0;
            end
            begin
                int          got = 0;
                bit          pend = 0;
                logic [26:0] pdat = '0;
                logic        plast = 0;
                while (got < nv * N_NEU) begin
                    @(negedge clk);
                    out_ready = (mode == 0) ? 1'b1 :
                                (mode == 1) ? cyc[0] : ($urandom_range(0, 2) != 0);
                    #1;
                    if (pend) begin
                        check(out_valid && out_data == pdat && out_last == plast,
                              "R6", longint'($signed(out_data)), longint'($signed(pdat)));
                    end
                    if (out_valid && out_ready) begin
                        check(longint'($signed(out_data)) == expq[got], req,
                              longint'($signed(out_data)), expq[got]);
                        check(out_last == ((got % N_NEU) == N_NEU - 1), "R3",
                              longint'(out_last), longint'((got % N_NEU) == N_NEU - 1));
                        got++;
                        pend = 0;
                    end else begin
                        pend = out_valid;
                        pdat = out_data;
                        plast = out_last;
                    end
                end
                @(negedge clk);
                out_ready = 1;
            end
        join
        stalls = st;
    endtask

    task automatic t_reset();
        rst = 1; out_ready = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(out_valid == 0, "R9", longint'(out_valid), 0);
        check(in_ready == 1, "R9", longint'(in_ready), 1);
    endtask

    task automatic t_latency();
        int e_acc, seen;
        gen_coefs(0); gen_inputs(1, 0); compute_exp(1);
        write_coefs();
        out_ready = 0;
        for (int k = 0; k < N_IN; k++) begin
            @(negedge clk);
            in_valid = 1; in_data = xm[0][k][26:0];
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        #1;
        e_acc = cyc;
        @(negedge clk);
        in_valid = 0;
        #1;
        seen = -1;
        if (out_valid) seen = cyc;
        while (seen < 0) begin
            @(negedge clk); #1;
            if (out_valid) seen = cyc;
            if (cyc - e_acc > 20) seen = cyc + 100;
        end
        check(seen - e_acc == LAT - 1, "R8", longint'(seen - e_acc), longint'(LAT - 1));
        // drain the vector and check the values (R2, element 0 loads the bias)
        for (int n = 0; n < N_NEU; n++) begin
            @(negedge clk);
            out_ready = 1;
            #1;
            check(out_valid && longint'($signed(out_data)) == expq[n], "R2",
                  longint'($signed(out_data)), expq[n]);
        end
        @(negedge clk);
    endtask

    task automatic t_stream_small();
        int st;
        gen_coefs(0); gen_inputs(6, 0); compute_exp(6);
        write_coefs();
        run_stream(6, 0, "R2", st);
        if (N_NEU > N_IN)
            check(st > 0, "R7", longint'(st), 1);
        else if (LAT == 1)
            check(st == 0, "R7", longint'(st), 0);
    endtask

    task automatic t_relu();
        int st;
        gen_coefs(0);
        for (int n = 0; n < N_NEU; n += 2) bm[n] = bm[n] - (64'sd1 <<< 23);
        gen_inputs(4, 0); compute_exp(4);
        write_coefs();
        run_stream(4, 0, "R4", st);
    endtask

    task automatic t_backpressure();
        int st;
        gen_coefs(0); gen_inputs(5, 0); compute_exp(5);
        write_coefs();
        run_stream(5, 1, "R7", st);
    endtask

    task automatic t_saturate();
        int st;
        gen_coefs(1); gen_inputs(VMAX, 1); compute_exp(VMAX);
        write_coefs();
        run_stream(VMAX, 2, "R5", st);
    endtask

    task automatic t_rewrite();
        int st;
        gen_coefs(0); gen_inputs(2, 0);
        write_coefs();
        wm[0][N_IN-1] = 17'sd65000;
        bm[N_NEU-1]   = 64'sd3000;
        @(negedge clk);
        cfg_we = 1; cfg_is_bias = 0; cfg_neuron = '0;
        cfg_index = IW'(N_IN - 1); cfg_value = 48'(wm[0][N_IN-1]);
        @(negedge clk);
        cfg_is_bias = 1; cfg_neuron = NW'(N_NEU - 1); cfg_value = 48'(bm[N_NEU-1]);
        @(negedge clk);
        cfg_we = 0;
        compute_exp(2);
        run_stream(2, 0, "R1", st);
    endtask

    initial begin
        rst = 1; cfg_we = 0; cfg_is_bias = 0; cfg_neuron = '0; cfg_index = '0;
        cfg_value = '0; in_valid = 0; in_data = '0; out_ready = 0;
        fin = 0; n_chk = 0; n_err = 0;
        wait (go);
        t_reset();
        t_latency();
        t_stream_small();
        t_relu();
        t_backpressure();
        t_saturate();
        t_rewrite();
        fin = 1;
    end
endmodule

// File: tb/sim_nnl_layer.sv
`timescale 1ns/1ps
module sim_nnl_layer;
    logic clk = 0;
    always #2.5 clk = ~clk;

    logic go_w = 0, go_n = 0;
    logic fin_w, fin_n;
    int   c_w, e_w, c_n, e_n;

    // more neurons than inputs: stall path, ReLU on, two-stage control
    nnl_case #(.N_IN(3), .N_NEU(5), .LAT(2), .RELU_EN(1), .FRAC(4),
               .TAG("wide")) u_wide (
        .clk(clk), .go(go_w), .fin(fin_w), .n_chk(c_w), .n_err(e_w));

    // fewer neurons than inputs: full rate, final layer without ReLU
    nnl_case #(.N_IN(5), .N_NEU(3), .LAT(1), .RELU_EN(0), .FRAC(2),
               .TAG("narrow")) u_narrow (
        .clk(clk), .go(go_n), .fin(fin_n), .n_chk(c_n), .n_err(e_n));

    initial begin
        bit timed_out = 0;
        int chk, err;
        fork
            begin
                go_w = 1;
                wait (fin_w);
                go_n = 1;
                wait (fin_n);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        chk = c_w + c_n;
        err = e_w + e_n;
        if (timed_out) begin
            chk++;
            err++;
            $display("FAIL watchdog (R7 flow): got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", chk, err);
        $finish;
    end
endmodule